// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between one bus master and one memory port. Two 32 MB address windows are treated as alias space. Each aligned 32-bit word in an alias window stands for a single bit of ordinary memory.

A read of an alias word returns that bit as 0 or 1. A write of an alias word sets or clears that one bit through a read-modify-write on the memory port. The memory access can be a byte, a halfword or a word, following the size of the master's request. Every other address goes straight through to the memory port with no change.

Both sides use a request/ready handshake. A transfer completes on a rising clock edge where request and ready are both high. The master holds its request and its fields steady until that edge. Size encoding on both sides: 2'b00 is a byte, 2'b01 is a halfword, and 2'b10 or 2'b11 is a word. Memory data is little-endian: the byte at address A uses data bits 8*A[1:0]+7 down to 8*A[1:0].

Top module: `bitband_bridge`

## Requirements
- R1: An address is alias space exactly when it lies in [0x22000000, 0x24000000) or in [0x42000000, 0x44000000). Alias requests are never forwarded as they are, and addresses 0x21FFFFFC, 0x24000000 and 0x44000000 are plain traffic.
- R2: For an alias request at address A, the memory address is (A & 0xE0000000) | ((A & 0x01FFFFFF) >> 5). Bit 0 of that address is forced to 0 for halfword size, and bits 1:0 are forced to 0 for word size.
- R3: The bit index is A[4:2] for byte size, A[5:2] for halfword size and A[6:2] for word size. It selects a bit within the natural byte lanes of the memory access: bus bit 8*M[1:0]+index for a byte, 16*M[1]+index for a halfword, and the index itself for a word, where M is the memory address before alignment.
- R4: An alias read completes with read data equal to 1 if the selected memory bit is set and 0 otherwise. Bits 31:1 of the read data are zero.
- R5: An alias write performs exactly one memory read followed by exactly one memory write to the same address and size. The write sets the selected bit when write-data bit 0 is 1 and clears it when that bit is 0. Every other bit of the written word keeps the value that was read.
- R6: Throughout an alias operation, master ready stays low until the memory phases are done. It is then high for exactly one cycle, and the bridge takes no new request before that cycle.
- R7: For a non-alias request, the memory request, write enable, address, size and write data equal the master's values in the same cycle. Master ready and read data equal the memory port's values in the same cycle.
- R8: After synchronous active-high reset the bridge is idle. With no master request there is no memory request, and master ready is low while memory ready is low.
- R9: During an alias write, write-data bits 31:1 have no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request valid |
| m_we | input | 1 | Master write enable |
| m_addr | input | 32 | Master byte address |
| m_size | input | 2 | Master access size |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Master transfer completes this cycle |
| m_rdata | output | 32 | Master read data |
| s_req | output | 1 | Memory request valid |
| s_we | output | 1 | Memory write enable |
| s_addr | output | 32 | Memory byte address |
| s_size | output | 2 | Memory access size |
| s_wdata | output | 32 | Memory write data |
| s_ready | input | 1 | Memory transfer completes this cycle |
| s_rdata | input | 32 | Memory read data |

## Verification
Two events can land on the same clock edge: capturing the fetched memory word at the end of the read phase, and raising the write-back request that depends on it. This happens when the memory model answers with its shortest delay.

The bench runs the read-modify-write sequences at both the shortest and a longer memory delay. It counts memory read and write handshakes per operation and compares the resulting memory words, so a write-back built from stale or uncaptured data shows up as a wrong word.

// File: rtl/bbb_pkg.sv
package bbb_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BIT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_REPLY
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        acc_size_e         size;
        logic [BIT_W-1:0]  pos;
        logic              we;
        logic              wbit;
    } alias_op_t;

    // Clear the low address bits that the access size does not use.
    function automatic logic [ADDR_W-1:0] align_addr(logic [ADDR_W-1:0] a, acc_size_e sz);
        logic [ADDR_W-1:0] r;
        r = a;
        case (sz)
            SZ_BYTE: r = a;
            SZ_HALF: r[0] = 1'b0;
            default: r[1:0] = 2'b00;
        endcase
        return r;
    endfunction

    // Position of the target bit on the little-endian data bus.
    function automatic logic [BIT_W-1:0] bus_pos(logic [1:0] lane, logic [BIT_W-1:0] idx,
                                                 acc_size_e sz);
        logic [BIT_W-1:0] p;
        case (sz)
            SZ_BYTE: p = {lane, idx[2:0]};
            SZ_HALF: p = {lane[1], idx[3:0]};
            default: p = idx;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bbb_decode.sv
module bbb_decode
    import bbb_pkg::*;
#(
    parameter logic [31:0] WIN0_BASE = 32'h2200_0000,
    parameter logic [31:0] WIN1_BASE = 32'h4200_0000,
    parameter int          WIN_BITS  = 25
) (
    input  logic [ADDR_W-1:2] addr_w,
    input  acc_size_e         size,
    input  logic              we,
    input  logic              wbit,
    output logic              hit,
    output alias_op_t         op
);
    localparam int                NWIN      = 2;
    localparam int                SHIFT     = BIT_W;
    localparam logic [ADDR_W-1:0] KEEP_MASK = 32'hE000_0000;
    localparam logic [ADDR_W-1:0] LOW_MASK  = (ADDR_W'(1) << WIN_BITS) - ADDR_W'(1);

    logic [NWIN-1:0]   hit_v;
    logic [ADDR_W-1:0] full;
    logic [ADDR_W-1:0] raw;
    logic [BIT_W-1:0]  idx;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam logic [31:0] BASE = (g == 0) ? WIN0_BASE : WIN1_BASE;
        assign hit_v[g] = (addr_w[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
    end

    assign hit  = |hit_v;
    assign full = {addr_w, 2'b00};
    assign raw  = (full & KEEP_MASK) | ((full & LOW_MASK) >> SHIFT);
    assign idx  = full[BIT_W+1:2];

    always_comb begin
        op.addr = align_addr(raw, size);
        op.size = size;
        op.pos  = bus_pos(raw[1:0], idx, size);
        op.we   = we;
        op.wbit = wbit;
    end

endmodule

// File: rtl/bbb_merge.sv
module bbb_merge
    import bbb_pkg::*;
(
    input  logic [DATA_W-1:0] rd_word,
    input  logic [BIT_W-1:0]  pos,
    input  logic              wbit,
    output logic              bit_val,
    output logic [DATA_W-1:0] wr_word
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign wr_word[i] = (pos == BIT_W'(i)) ? wbit : rd_word[i];
    end

    assign bit_val = rd_word[pos];

endmodule

// File: rtl/bbb_ctrl.sv
module bbb_ctrl
    import bbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              m_req,
    input  logic              hit,
    input  alias_op_t         op_in,
    input  logic              s_ready,
    input  logic [DATA_W-1:0] s_rdata,
    output logic              busy,
    output logic              a_req,
    output logic              a_we,
    output logic [ADDR_W-1:0] a_addr,
    output logic [1:0]        a_size,
    output logic [DATA_W-1:0] a_wdata,
    output logic              a_ready,
    output logic [DATA_W-1:0] a_rdata
);
    phase_e            state;
    alias_op_t         op_q;
    logic [DATA_W-1:0] data_q;
    logic              bit_val;
    logic [DATA_W-1:0] wr_word;

    bbb_merge u_merge (
        .rd_word (data_q),
        .pos     (op_q.pos),
        .wbit    (op_q.wbit),
        .bit_val (bit_val),
        .wr_word (wr_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (m_req && hit) begin
                    op_q  <= op_in;
                    state <= ST_FETCH;
                end
                ST_FETCH: if (s_ready) begin
                    data_q <= s_rdata;
                    state  <= op_q.we ? ST_STORE : ST_REPLY;
                end
                ST_STORE: if (s_ready) state <= ST_REPLY;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        a_req   = (state == ST_FETCH) || (state == ST_STORE);
        a_we    = (state == ST_STORE);
        a_addr  = op_q.addr;
        a_size  = op_q.size;
        a_wdata = wr_word;
        a_ready = (state == ST_REPLY);
        a_rdata = {{(DATA_W-1){1'b0}}, bit_val};
    end

    AST_REPLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REPLY) |=> (state == ST_IDLE)); // R6
    AST_LAUNCH_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(m_req && hit)); // R1

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bbb_pkg::*;
#(
    parameter logic [31:0] WIN0_BASE = 32'h2200_0000,
    parameter logic [31:0] WIN1_BASE = 32'h4200_0000,
    parameter int          WIN_BITS  = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        m_req,
    input  logic        m_we,
    input  logic [31:0] m_addr,
    input  logic [1:0]  m_size,
    input  logic [31:0] m_wdata,
    output logic        m_ready,
    output logic [31:0] m_rdata,
    output logic        s_req,
    output logic        s_we,
    output logic [31:0] s_addr,
    output logic [1:0]  s_size,
    output logic [31:0] s_wdata,
    input  logic        s_ready,
    input  logic [31:0] s_rdata
);
    logic              hit;
    alias_op_t         op;
    logic              busy;
    logic              a_req;
    logic              a_we;
    logic [ADDR_W-1:0] a_addr;
    logic [1:0]        a_size;
    logic [DATA_W-1:0] a_wdata;
    logic              a_ready;
    logic [DATA_W-1:0] a_rdata;

    bbb_decode #(
        .WIN0_BASE (WIN0_BASE),
        .WIN1_BASE (WIN1_BASE),
        .WIN_BITS  (WIN_BITS)
    ) u_decode (
        .addr_w (m_addr[31:2]),
        .size   (acc_size_e'(m_size)),
        .we     (m_we),
        .wbit   (m_wdata[0]),
        .hit    (hit),
        .op     (op)
    );

    bbb_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .m_req   (m_req),
        .hit     (hit),
        .op_in   (op),
        .s_ready (s_ready),
        .s_rdata (s_rdata),
        .busy    (busy),
        .a_req   (a_req),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_size  (a_size),
        .a_wdata (a_wdata),
        .a_ready (a_ready),
        .a_rdata (a_rdata)
    );

    always_comb begin
        if (busy) begin
            s_req   = a_req;
            s_we    = a_we;
            s_addr  = a_addr;
            s_size  = a_size;
            s_wdata = a_wdata;
            m_ready = a_ready;
            m_rdata = a_rdata;
        end else begin
            s_req   = m_req && !hit;
            s_we    = m_we;
            s_addr  = m_addr;
            s_size  = m_size;
            s_wdata = m_wdata;
            m_ready = s_ready && !hit;
            m_rdata = s_rdata;
        end
    end

    AST_ALIAS_NOT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        (!busy && m_req && hit) |-> !s_req); // R1
    AST_REAL_REGION: assert property (@(posedge clk) disable iff (rst)
        (busy && s_req) |-> (s_addr[28:WIN_BITS-5] == '0)); // R2
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (busy && s_req && s_size[1]) |-> (s_addr[1:0] == 2'b00)); // R2
    AST_RESP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (busy && m_ready) |-> (m_rdata[31:1] == '0)); // R4
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (busy && s_req && s_we) |-> ($past(s_req && s_ready) || $past(s_req && s_we && !s_ready))); // R5
    AST_READY_LOW_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
        (busy && s_req) |-> !m_ready); // R6
    AST_PASS_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (!busy && m_req && !hit) |-> (s_addr == m_addr && s_size == m_size && s_req)); // R7

endmodule

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_req = 1'b0, m_we = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic [1:0]  m_size = 2'b10;
    logic        m_ready, s_req, s_we, s_ready;
    logic [31:0] m_rdata, s_addr, s_wdata, s_rdata;
    logic [1:0]  s_size;

    int checks = 0, errors = 0;
    int lat = 1;
    int wcnt = 0, rd_cnt = 0, wr_cnt = 0, acc_cnt = 0;
    logic        mem_rdy = 1'b0;
    logic [31:0] mem [0:255];
    logic [31:0] last_addr = '0;

    always #2.5 clk = ~clk;

    bitband_bridge u_bitband_bridge (
        .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_size(m_size), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata),
        .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_size(s_size),
        .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata)
    );

    assign s_ready = mem_rdy;
    assign s_rdata = mem[s_addr[9:2]];

    function automatic logic [31:0] lanes(logic [31:0] old, logic [31:0] d,
                                          logic [1:0] a, logic [1:0] sz);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) begin
            logic en;
            en = sz[1] ? 1'b1 : (sz[0] ? (a[1] == b[1]) : (a == b[1:0]));
            if (en) r[8*b +: 8] = d[8*b +: 8];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_rdy <= 1'b0;
            wcnt    <= 0;
        end else if (s_req && mem_rdy) begin
            mem_rdy   <= 1'b0;
            wcnt      <= 0;
            last_addr <= s_addr;
            if (s_we) begin
                mem[s_addr[9:2]] <= lanes(mem[s_addr[9:2]], s_wdata, s_addr[1:0], s_size);
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end else if (s_req) begin
            if (wcnt >= lat) mem_rdy <= 1'b1;
            else wcnt <= wcnt + 1;
        end
        if (!rst && m_req && m_ready) acc_cnt <= acc_cnt + 1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(logic we, logic [31:0] addr, logic [1:0] sz, logic [31:0] wd,
                        output logic [31:0] rd);
        @(negedge clk);
        m_req = 1'b1; m_we = we; m_addr = addr; m_size = sz; m_wdata = wd;
        #1;
        while (!m_ready) @(negedge clk);
        rd = m_rdata;
        @(negedge clk);
        m_req = 1'b0; m_we = 1'b0;
    endtask

    function automatic logic [31:0] alias_of(logic [31:0] base, logic [31:0] off, int k);
        return base + off * 32 + 32'(k) * 4;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R8 s_req idle", {31'b0, s_req}, 32'd0);
        chk("R8 m_ready idle", {31'b0, m_ready}, 32'd0);
        m_req = 1'b1; m_addr = 32'h2000_0040; m_size = 2'b10;
        #1;
        chk("R8 pass after reset", {31'b0, s_req}, 32'd1);
        chk("R7 addr forwarded", s_addr, 32'h2000_0040);
        m_req = 1'b0;
    endtask

    task automatic t_pass();
        logic [31:0] rd;
        xfer(1'b1, 32'h2000_0010, 2'b10, 32'hDEAD_BEEF, rd);
        chk("R7 pass word write", mem[4], 32'hDEAD_BEEF);
        xfer(1'b1, 32'h2000_0013, 2'b00, 32'h7700_0000, rd);
        chk("R7 pass byte lane", mem[4], 32'h77AD_BEEF);
        xfer(1'b0, 32'h2000_0010, 2'b10, 32'h0, rd);
        chk("R7 pass read", rd, 32'h77AD_BEEF);
    endtask

    task automatic t_alias_read();
        logic [31:0] rd;
        mem[8] = 32'h8000_0481;
        xfer(1'b0, alias_of(32'h2200_0000, 32'h20, 0), 2'b10, 0, rd);
        chk("R4 word bit0", rd, 32'd1);
        xfer(1'b0, alias_of(32'h2200_0000, 32'h20, 31), 2'b10, 0, rd);
        chk("R4 word bit31", rd, 32'd1);
        xfer(1'b0, alias_of(32'h2200_0000, 32'h20, 5), 2'b10, 0, rd);
        chk("R4 word bit5 clear", rd, 32'd0);
        xfer(1'b0, alias_of(32'h2200_0000, 32'h23, 7), 2'b00, 0, rd);
        chk("R3 byte lane3 bit7", rd, 32'd1);
        xfer(1'b0, alias_of(32'h2200_0000, 32'h22, 15), 2'b01, 0, rd);
        chk("R3 half upper bit15", rd, 32'd1);
        xfer(1'b0, alias_of(32'h2200_0000, 32'h22, 0), 2'b01, 0, rd);
        chk("R3 half upper bit0", rd, 32'd0);
        xfer(1'b0, alias_of(32'h2200_0000, 32'h21, 2), 2'b01, 0, rd);
        chk("R3 half odd addr bit index 10", rd, 32'd1);
        chk("R2 half aligned address", last_addr, 32'h2000_0020);
    endtask

    task automatic t_alias_write(int l);
        logic [31:0] rd;
        int r0, w0, a0;
        lat = l;
        mem[9] = 32'h0F0F_0F0F;
        r0 = rd_cnt; w0 = wr_cnt; a0 = acc_cnt;
        xfer(1'b1, alias_of(32'h2200_0000, 32'h24, 4), 2'b10, 32'd1, rd);
        chk("R5 word set", mem[9], 32'h0F0F_0F1F);
        chk("R5 one read", 32'(rd_cnt - r0), 32'd1);
        chk("R5 one write", 32'(wr_cnt - w0), 32'd1);
        chk("R6 single ready", 32'(acc_cnt - a0), 32'd1);
        xfer(1'b1, alias_of(32'h2200_0000, 32'h26, 3), 2'b00, 32'hFFFF_FFFE, rd);
        chk("R9 byte clear ignores upper data", mem[9], 32'h0F07_0F1F);
        xfer(1'b1, alias_of(32'h2200_0000, 32'h24, 13), 2'b01, 32'h0000_0003, rd);
        chk("R5 half set", mem[9], 32'h0F07_2F1F);
        xfer(1'b1, alias_of(32'h2200_0000, 32'h24, 0), 2'b10, 32'h0000_0001, rd);
        chk("R5 set already set", mem[9], 32'h0F07_2F1F);
        lat = 1;
    endtask

    task automatic t_window2();
        logic [31:0] rd;
        lat = 3;
        mem[2] = 32'h0001_0000;
        xfer(1'b0, alias_of(32'h4200_0000, 32'h08, 16), 2'b10, 0, rd);
        chk("R1 window2 read", rd, 32'd1);
        chk("R2 window2 address", last_addr, 32'h4000_0008);
        xfer(1'b1, alias_of(32'h4200_0000, 32'h08, 16), 2'b10, 32'h0, rd);
        chk("R5 window2 clear", mem[2], 32'h0);
        lat = 1;
    endtask

    task automatic t_edges();
        logic [31:0] rd;
        mem[255] = 32'h1234_5678;
        mem[0]   = 32'hCAFE_F00D;
        xfer(1'b0, 32'h21FF_FFFC, 2'b10, 0, rd);
        chk("R1 below window passes", rd, 32'h1234_5678);
        xfer(1'b0, 32'h2400_0000, 2'b10, 0, rd);
        chk("R1 above window passes", rd, 32'hCAFE_F00D);
        chk("R1 above window address", last_addr, 32'h2400_0000);
        xfer(1'b0, 32'h4400_0000, 2'b10, 0, rd);
        chk("R1 above window2 passes", rd, 32'hCAFE_F00D);
        xfer(1'b0, 32'h23FF_FFFC, 2'b10, 0, rd);
        chk("R2 top alias bit", rd, 32'd0);
        chk("R2 top alias address", last_addr, 32'h200F_FFFC);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pass();
        t_alias_read();
        t_alias_write(0);
        t_alias_write(3);
        t_window2();
        t_edges();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule